// File: doc/BRIEF.md
# Linearized Track Parameter Fitter

This block turns a coarse track candidate into precise track parameters without any iteration. Each candidate arrives as a road number plus one full-resolution signed hit coordinate per detector layer. For the road, a constant store holds precomputed linear coefficients. The block forms impact parameter, azimuth and curvature as an offset plus a fixed-point scalar product of coefficients and coordinates. It forms a fit-quality figure as the sum of squares of several constraint scalar products.

The datapath is a three-stage pipeline that takes one road per clock and returns results in order after a fixed latency. Valid/ready handshakes control both sides, and a stalled output freezes the whole pipeline. Coefficients are written one word at a time through a plain write port. A chi-square threshold input decides whether a result is marked good or rejected. Every parameter output saturates at the limits of its range rather than wrapping.

Top module: `lintf_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A write with `cfg_we`=1 stores `cfg_data` into word `cfg_word` of road `cfg_road`. Words 0, 1 and 2 are the impact, azimuth and curvature offsets. Word 3 + t*NLAYER + i is the coefficient of layer i for term t. Terms 0–2 are impact, azimuth and curvature, and terms 3 to 3+NCHI-1 are the chi-square constraints. Layer i occupies bits [i*XW +: XW] of `in_hits`.
- R3: Impact parameter = sat(off0 + ((sum over i of c[0][i]*x[i]) >>> FRAC)), where >>> is an arithmetic shift.
- R4: Azimuth and curvature follow the R3 form, using offsets 1 and 2 and terms 1 and 2.
- R5: chi = sum over k of t_k squared. Each t_k = sat16((sum over i of c[3+k][i]*x[i]) >>> FRAC). The total saturates to 2^CHI_W-1.
- R6: `out_good` is 1 exactly when chi <= `chi_limit`. A rejected track is still delivered with `out_valid` and `out_good`=0.
- R7: Each parameter output saturates to the signed OW-bit range, [-2^(OW-1), 2^(OW-1)-1].
- R8: A road accepted at a clock edge appears on the outputs after the third clock edge counted from that accept. Back-to-back roads are accepted on consecutive cycles and delivered in order on consecutive cycles.
- R9: While `out_valid`=1 and `out_ready`=0, every output holds stable and `in_ready` is 0. No road is lost or duplicated.
- R10: Each road uses only its own constants, and the road number is carried to `out_road`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Constant write strobe |
| cfg_road | input | RW | Road whose constants are written |
| cfg_word | input | WIW | Word index within the road record |
| cfg_data | input | CW | Signed constant value |
| chi_limit | input | CHI_W | Chi-square acceptance threshold |
| in_valid | input | 1 | Input road present |
| in_ready | output | 1 | Block can take a road this cycle |
| in_road | input | RW | Road number |
| in_hits | input | NLAYER*XW | Signed hit coordinates, layer i at [i*XW +: XW] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_road | output | RW | Road number of the result |
| out_d | output | OW | Impact parameter, saturated |
| out_phi | output | OW | Azimuth, saturated |
| out_crv | output | OW | Curvature, saturated |
| out_chi | output | CHI_W | Chi-square, saturated |
| out_good | output | 1 | Chi-square within threshold |

## Verification
The bench builds the fitter with eight roads, FRAC of 4 and a 20-bit chi-square field. The other values stay at their defaults of six layers, three constraints and 16-bit words. The short shift lets modest coefficients drive the parameter outputs into both saturation rails. The narrow chi-square field lets the quality sum reach its ceiling, while small coefficients still allow an exact threshold comparison with equality and with a margin of one. With eight roads, distinct constant sets can be checked side by side in one stream, both at full rate and under irregular output backpressure.

// File: rtl/lintf_pkg.sv
`timescale 1ns/1ps
package lintf_pkg;

    // number of linear track parameters produced per road
    localparam int NPAR = 3;

    typedef enum logic [1:0] {
        SEL_D   = 2'd0,
        SEL_PHI = 2'd1,
        SEL_CRV = 2'd2
    } par_sel_e;

    // word holding the offset of parameter p
    function automatic int off_word(input int p);
        return p;
    endfunction

    // word holding coefficient of layer 'layer' for term 'term'
    // terms 0..NPAR-1 are parameters, the rest are chi-square constraints
    function automatic int coef_word(input int term, input int layer, input int nlayer);
        return NPAR + term * nlayer + layer;
    endfunction

    function automatic int record_words(input int nlayer, input int nchi);
        return NPAR + (NPAR + nchi) * nlayer;
    endfunction

endpackage

// File: rtl/lintf_const_mem.sv
`timescale 1ns/1ps
module lintf_const_mem #(
    parameter int NROAD = 16,
    parameter int NWORD = 39,
    parameter int CW    = 16,
    parameter int RW    = 4,
    parameter int WIW   = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [RW-1:0]         wr_road,
    input  logic [WIW-1:0]        wr_word,
    input  logic [CW-1:0]         wr_data,
    input  logic [RW-1:0]         rd_road,
    output logic [NWORD*CW-1:0]   rd_rec
);

    logic [NWORD*CW-1:0] store [NROAD];
    logic                wr_ok;

    assign wr_ok = wr_en && (int'(wr_word) < NWORD) && (int'(wr_road) < NROAD);

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            store[wr_road][int'(wr_word)*CW +: CW] <= wr_data;
        end
    end

    assign rd_rec = store[rd_road];

    // R2: a write lands in the addressed word of the addressed road
    p_cfg_store_r2: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> store[$past(wr_road)][int'($past(wr_word))*CW +: CW] == $past(wr_data));

endmodule

// File: rtl/lintf_dot.sv
`timescale 1ns/1ps
module lintf_dot #(
    parameter int NLAYER = 6,
    parameter int XW     = 16,
    parameter int CW     = 16,
    parameter int ACC_W  = 35
) (
    input  logic [NLAYER*XW-1:0]     x_flat,
    input  logic [NLAYER*CW-1:0]     c_flat,
    output logic signed [ACC_W-1:0]  sum
);

    logic signed [XW-1:0]    xv   [NLAYER];
    logic signed [CW-1:0]    cv   [NLAYER];
    logic signed [ACC_W-1:0] prod [NLAYER];

    for (genvar i = 0; i < NLAYER; i++) begin : g_term
        assign xv[i]   = x_flat[i*XW +: XW];
        assign cv[i]   = c_flat[i*CW +: CW];
        assign prod[i] = ACC_W'(xv[i]) * ACC_W'(cv[i]);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < NLAYER; i++) begin
            sum = sum + prod[i];
        end
    end

endmodule

// File: rtl/lintf_finish.sv
`timescale 1ns/1ps
module lintf_finish #(
    parameter int NPAR  = 3,
    parameter int NCHI  = 3,
    parameter int CW    = 16,
    parameter int ACC_W = 35,
    parameter int OW    = 16,
    parameter int CHI_W = 24,
    parameter int FRAC  = 8
) (
    input  logic [(NPAR+NCHI)*ACC_W-1:0] dot_flat,
    input  logic [NPAR*CW-1:0]           off_flat,
    input  logic [CHI_W-1:0]             chi_limit,
    output logic [NPAR*OW-1:0]           par_flat,
    output logic [CHI_W-1:0]             chi,
    output logic                         good
);

    localparam int EW   = ACC_W + 1;
    localparam int SQW  = 2 * OW;
    localparam int SUMW = SQW + $clog2(NCHI) + 1;
    localparam logic signed [EW-1:0]    EMAX = EW'((64'sd1 <<< (OW-1)) - 64'sd1);
    localparam logic signed [EW-1:0]    EMIN = -EMAX - EW'(1);
    localparam logic signed [ACC_W-1:0] TMAX = ACC_W'((64'sd1 <<< (OW-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] TMIN = -TMAX - ACC_W'(1);
    localparam logic [SUMW-1:0]         CMAX = SUMW'((64'd1 << CHI_W) - 64'd1);

    // parameter outputs: offset plus scaled dot product, clamped
    for (genvar p = 0; p < NPAR; p++) begin : g_par
        logic signed [ACC_W-1:0] dv;
        logic signed [ACC_W-1:0] sh;
        logic signed [CW-1:0]    ov;
        logic signed [EW-1:0]    tot;
        assign dv  = dot_flat[p*ACC_W +: ACC_W];
        assign sh  = dv >>> FRAC;
        assign ov  = off_flat[p*CW +: CW];
        assign tot = EW'(sh) + EW'(ov);
        assign par_flat[p*OW +: OW] = (tot > EMAX) ? EMAX[OW-1:0] :
                                      (tot < EMIN) ? EMIN[OW-1:0] : tot[OW-1:0];
    end

    // constraint terms: scale, clamp to OW bits, square
    logic signed [SQW-1:0] sq [NCHI];
    for (genvar k = 0; k < NCHI; k++) begin : g_chi
        logic signed [ACC_W-1:0] dv;
        logic signed [ACC_W-1:0] sh;
        logic signed [OW-1:0]    tk;
        assign dv = dot_flat[(NPAR+k)*ACC_W +: ACC_W];
        assign sh = dv >>> FRAC;
        assign tk = (sh > TMAX) ? TMAX[OW-1:0] :
                    (sh < TMIN) ? TMIN[OW-1:0] : sh[OW-1:0];
        assign sq[k] = SQW'(tk) * SQW'(tk);
    end

    logic [SUMW-1:0] acc;
    always_comb begin
        acc = '0;
        for (int k = 0; k < NCHI; k++) begin
            acc = acc + {{(SUMW-SQW){1'b0}}, sq[k]};
        end
    end

    assign chi  = (acc > CMAX) ? CMAX[CHI_W-1:0] : acc[CHI_W-1:0];
    assign good = (chi <= chi_limit);

endmodule

// File: rtl/lintf_top.sv
`timescale 1ns/1ps
module lintf_top
    import lintf_pkg::*;
#(
    parameter int NLAYER = 6,
    parameter int NCHI   = 3,
    parameter int NROAD  = 16,
    parameter int XW     = 16,
    parameter int CW     = 16,
    parameter int OW     = 16,
    parameter int CHI_W  = 24,
    parameter int FRAC   = 8,
    localparam int RW    = (NROAD > 1) ? $clog2(NROAD) : 1,
    localparam int NWORD = NPAR + (NPAR + NCHI) * NLAYER,
    localparam int WIW   = $clog2(NWORD)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [RW-1:0]         cfg_road,
    input  logic [WIW-1:0]        cfg_word,
    input  logic [CW-1:0]         cfg_data,
    input  logic [CHI_W-1:0]      chi_limit,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [RW-1:0]         in_road,
    input  logic [NLAYER*XW-1:0]  in_hits,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [RW-1:0]         out_road,
    output logic [OW-1:0]         out_d,
    output logic [OW-1:0]         out_phi,
    output logic [OW-1:0]         out_crv,
    output logic [CHI_W-1:0]      out_chi,
    output logic                  out_good
);

    localparam int ACC_W = XW + CW + $clog2(NLAYER);
    localparam int NT    = NPAR + NCHI;

    logic                   adv;
    logic                   s1_v, s2_v;
    logic [RW-1:0]          s1_road, s2_road;
    logic [NLAYER*XW-1:0]   s1_hits;
    logic [NWORD*CW-1:0]    rec;
    logic [NT*ACC_W-1:0]    dot_c, s2_dot;
    logic [NPAR*CW-1:0]     off_c, s2_off;
    logic [NPAR*OW-1:0]     par_c;
    logic [CHI_W-1:0]       chi_c;
    logic                   good_c;

    // whole pipeline advances unless a result is waiting on the consumer
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    lintf_const_mem #(
        .NROAD(NROAD), .NWORD(NWORD), .CW(CW), .RW(RW), .WIW(WIW)
    ) u_const (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_road(cfg_road),
        .wr_word(cfg_word), .wr_data(cfg_data),
        .rd_road(s1_road), .rd_rec(rec)
    );

    for (genvar g = 0; g < NT; g++) begin : g_dot
        lintf_dot #(
            .NLAYER(NLAYER), .XW(XW), .CW(CW), .ACC_W(ACC_W)
        ) u_dot (
            .x_flat(s1_hits),
            .c_flat(rec[coef_word(g, 0, NLAYER)*CW +: NLAYER*CW]),
            .sum(dot_c[g*ACC_W +: ACC_W])
        );
    end

    for (genvar p = 0; p < NPAR; p++) begin : g_off
        assign off_c[p*CW +: CW] = rec[off_word(p)*CW +: CW];
    end

    lintf_finish #(
        .NPAR(NPAR), .NCHI(NCHI), .CW(CW), .ACC_W(ACC_W),
        .OW(OW), .CHI_W(CHI_W), .FRAC(FRAC)
    ) u_finish (
        .dot_flat(s2_dot), .off_flat(s2_off), .chi_limit(chi_limit),
        .par_flat(par_c), .chi(chi_c), .good(good_c)
    );

    // valid chain
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v      <= 1'b0;
            s2_v      <= 1'b0;
            out_valid <= 1'b0;
        end else if (adv) begin
            s1_v      <= in_valid;
            s2_v      <= s1_v;
            out_valid <= s2_v;
        end
    end

    // data chain
    always_ff @(posedge clk) begin
        if (adv) begin
            s1_road  <= in_road;
            s1_hits  <= in_hits;
            s2_road  <= s1_road;
            s2_dot   <= dot_c;
            s2_off   <= off_c;
            out_road <= s2_road;
            out_d    <= par_c[int'(SEL_D)*OW   +: OW];
            out_phi  <= par_c[int'(SEL_PHI)*OW +: OW];
            out_crv  <= par_c[int'(SEL_CRV)*OW +: OW];
            out_chi  <= chi_c;
            out_good <= good_c;
        end
    end

    // R9: a stalled result stays put
    p_hold_outputs_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_road) &&
        $stable(out_d) && $stable(out_phi) && $stable(out_crv) &&
        $stable(out_chi) && $stable(out_good)));

    // R9: input blocked while a result waits
    p_block_input_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R6: good flag agrees with the threshold present when it was loaded
    p_good_limit_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_ready)) |-> (out_good == (out_chi <= $past(chi_limit))));

    // R8: with no stall, a result follows an accept three edges earlier
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_ready, 1) && $past(in_ready, 2) && $past(in_ready, 3))
        |-> $past(in_valid, 3));

endmodule

// File: tb/lintf_top_bench.sv
`timescale 1ns/1ps
module lintf_top_bench;

    localparam int NL  = 6;
    localparam int NC  = 3;
    localparam int NR  = 8;
    localparam int XW  = 16;
    localparam int CW  = 16;
    localparam int OW  = 16;
    localparam int CHW = 20;
    localparam int FR  = 4;
    localparam int NP  = 3;
    localparam int NW  = NP + (NP + NC) * NL;
    localparam int RW  = 3;
    localparam int WIW = 6;
    localparam longint PMAX = 32767;
    localparam longint PMIN = -32768;
    localparam longint CMAX = (64'sd1 <<< CHW) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_we = 1'b0;
    logic [RW-1:0]      cfg_road = '0;
    logic [WIW-1:0]     cfg_word = '0;
    logic [CW-1:0]      cfg_data = '0;
    logic [CHW-1:0]     chi_limit = '0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [RW-1:0]      in_road = '0;
    logic [NL*XW-1:0]   in_hits = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [RW-1:0]      out_road;
    logic [OW-1:0]      out_d, out_phi, out_crv;
    logic [CHW-1:0]     out_chi;
    logic               out_good;

    int checks = 0;
    int errors = 0;
    int cst [NR][NW];

    always #10 clk = ~clk;

    lintf_top #(
        .NLAYER(NL), .NCHI(NC), .NROAD(NR), .XW(XW), .CW(CW),
        .OW(OW), .CHI_W(CHW), .FRAC(FR)
    ) u_lintf_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_road(cfg_road),
        .cfg_word(cfg_word), .cfg_data(cfg_data), .chi_limit(chi_limit),
        .in_valid(in_valid), .in_ready(in_ready), .in_road(in_road),
        .in_hits(in_hits), .out_valid(out_valid), .out_ready(out_ready),
        .out_road(out_road), .out_d(out_d), .out_phi(out_phi),
        .out_crv(out_crv), .out_chi(out_chi), .out_good(out_good)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat(input longint v, input longint lo, input longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint term_dot(input int r, input int t, input int h[NL]);
        longint s = 0;
        for (int i = 0; i < NL; i++) s += longint'(cst[r][NP + t*NL + i]) * longint'(h[i]);
        return s;
    endfunction

    function automatic longint model_par(input int r, input int p, input int h[NL]);
        return sat(longint'(cst[r][p]) + (term_dot(r, p, h) >>> FR), PMIN, PMAX);
    endfunction

    function automatic longint model_chi(input int r, input int h[NL]);
        longint acc = 0;
        for (int k = 0; k < NC; k++) begin
            longint t = sat(term_dot(r, NP + k, h) >>> FR, PMIN, PMAX);
            acc += t * t;
        end
        return sat(acc, 0, CMAX);
    endfunction

    task automatic load(input int r, input int w, input int v);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_road = RW'(r);
        cfg_word = WIW'(w);
        cfg_data = CW'(v);
        cst[r][w] = v;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic drive_hits(input int h[NL]);
        for (int i = 0; i < NL; i++) in_hits[i*XW +: XW] = h[i][XW-1:0];
    endtask

    // one road through an empty pipeline, checked at the exact output cycle
    task automatic run_one(input string req, input int r, input int h[NL], input int lim);
        @(negedge clk);
        out_ready = 1'b1;
        chi_limit = CHW'(lim);
        in_valid  = 1'b1;
        in_road   = RW'(r);
        drive_hits(h);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8", "valid before third edge", longint'(out_valid), 0);
        @(negedge clk);
        chk("R8", "valid at third edge", longint'(out_valid), 1);
        chk("R10", {req, " road"}, longint'(out_road), longint'(r));
        chk(req, "impact", longint'($signed(out_d)), model_par(r, 0, h));
        chk(req, "azimuth", longint'($signed(out_phi)), model_par(r, 1, h));
        chk(req, "curvature", longint'($signed(out_crv)), model_par(r, 2, h));
        chk(req, "chi", longint'(out_chi), model_chi(r, h));
        chk("R6", {req, " good"}, longint'(out_good), longint'(model_chi(r, h) <= longint'(lim)));
    endtask

    task automatic t_reset();
        chk("R1", "out_valid after reset", longint'(out_valid), 0);
        chk("R1", "in_ready after reset", longint'(in_ready), 1);
    endtask

    task automatic t_basic();
        int ha[NL] = '{10, -20, 35, 7, -3, 50};
        int hb[NL] = '{-100, 90, -80, 70, -60, 50};
        run_one("R3", 2, ha, 1000000);
        run_one("R4", 2, hb, 1000000);
        run_one("R10", 5, ha, 1000000);
        run_one("R10", 6, hb, 1000000);
    endtask

    task automatic t_reload();
        int ha[NL] = '{12, 34, -56, 78, -9, 1};
        load(2, 0, -1234);
        load(2, NP + 0*NL + 2, 400);
        load(2, NP + 1*NL + 5, -300);
        run_one("R2", 2, ha, 1000000);
        chk("R2", "offset only word 0", longint'(cst[2][0]), -1234);
    endtask

    task automatic t_param_sat();
        int hs[NL] = '{32767, 32767, 32767, 32767, 32767, 32767};
        for (int i = 0; i < NL; i++) begin
            load(1, NP + 0*NL + i, 32767);
            load(1, NP + 1*NL + i, -32768);
            load(1, NP + 2*NL + i, 0);
        end
        load(1, 0, 32767);
        load(1, 1, -32768);
        load(1, 2, -77);
        run_one("R7", 1, hs, 0);
        chk("R7", "impact upper rail", longint'($signed(out_d)), PMAX);
        chk("R7", "azimuth lower rail", longint'($signed(out_phi)), PMIN);
        chk("R7", "curvature unclamped", longint'($signed(out_crv)), -77);
    endtask

    task automatic t_chi();
        int hc[NL] = '{40, 40, 40, 40, 40, 40};
        longint cv;
        for (int k = 0; k < NC; k++)
            for (int i = 0; i < NL; i++) load(3, NP + (NP + k)*NL + i, k + 1);
        cv = model_chi(3, hc);
        run_one("R5", 3, hc, int'(cv));
        chk("R6", "equal limit good", longint'(out_good), 1);
        run_one("R6", 3, hc, int'(cv) - 1);
        chk("R6", "limit one below rejected", longint'(out_good), 0);
        chk("R6", "rejected still valid", longint'(out_valid), 1);
        for (int k = 0; k < NC; k++)
            for (int i = 0; i < NL; i++) load(4, NP + (NP + k)*NL + i, 3000);
        run_one("R5", 4, hc, 5);
        chk("R5", "chi ceiling", longint'(out_chi), CMAX);
    endtask

    // stream of roads with a pattern of output stalls
    task automatic t_stream(input string req, input int mode);
        localparam int N = 10;
        int hs[N][NL];
        int rs[N];
        longint ed[N], ep[N], ec[N], ex[N];
        int snd = 0, rcv = 0, cyc = 0, gap = 0;
        bit held = 0, saw_block = 0, prev_consec = 0;
        logic [OW-1:0] hd;
        logic [CHW-1:0] hx;
        for (int n = 0; n < N; n++) begin
            rs[n] = (n * 3 + 1) % NR;
            for (int i = 0; i < NL; i++) hs[n][i] = ((n * 17 + i * 31) % 201) - 100;
            ed[n] = model_par(rs[n], 0, hs[n]);
            ep[n] = model_par(rs[n], 1, hs[n]);
            ec[n] = model_par(rs[n], 2, hs[n]);
            ex[n] = model_chi(rs[n], hs[n]);
        end
        chi_limit = CHW'(CMAX);
        while (rcv < N && cyc < 400) begin
            @(negedge clk);
            if (held) begin
                chk("R9", "held valid", longint'(out_valid), 1);
                chk("R9", "held impact", longint'(out_d), longint'(hd));
                chk("R9", "held chi", longint'(out_chi), longint'(hx));
            end
            out_ready = (mode == 0) ? 1'b1 : (cyc < 6) ? 1'b0 : (cyc % 3 != 0);
            if (snd < N) begin
                in_valid = 1'b1;
                in_road  = RW'(rs[snd]);
                drive_hits(hs[snd]);
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (out_valid && !out_ready && !in_ready) saw_block = 1;
            held = out_valid && !out_ready;
            hd = out_d;
            hx = out_chi;
            if (out_valid && out_ready) begin
                chk(req, "stream road", longint'(out_road), longint'(rs[rcv]));
                chk(req, "stream impact", longint'($signed(out_d)), ed[rcv]);
                chk(req, "stream azimuth", longint'($signed(out_phi)), ep[rcv]);
                chk(req, "stream curvature", longint'($signed(out_crv)), ec[rcv]);
                chk(req, "stream chi", longint'(out_chi), ex[rcv]);
                if (mode == 0 && rcv > 0 && !prev_consec) gap++;
                prev_consec = 1;
                rcv++;
            end else begin
                prev_consec = 0;
            end
            if (in_valid && in_ready) snd++;
            cyc++;
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        chk(req, "all results delivered", longint'(rcv), longint'(N));
        if (mode == 0) begin
            chk("R8", "no gaps at full rate", longint'(gap), 0);
            chk("R8", "full-rate cycle count", longint'(cyc), longint'(N + 3));
        end else begin
            chk("R9", "input blocked during stall", longint'(saw_block), 1);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++)
            for (int w = 0; w < NW; w++) cst[r][w] = ((r * 53 + w * 29) % 97) - 48;
        repeat (3) @(posedge clk);
        chk("R1", "out_valid in reset", longint'(out_valid), 0);
        #1 rst = 1'b0;
        for (int r = 0; r < NR; r++)
            for (int w = 0; w < NW; w++) load(r, w, cst[r][w]);
        t_reset();
        t_basic();
        t_reload();
        t_param_sat();
        t_chi();
        t_stream("R8", 0);
        t_stream("R9", 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule